// File: doc/BRIEF.md
# Two-digit BCD up/down occupancy counter

This block keeps a running count of the vehicles inside a car park as a two-digit decimal number from 00 to 99. Upstream sensing logic sends a one-cycle strobe on `up_i` when a vehicle enters and a one-cycle strobe on `dn_i` when one leaves. Both strobes are already synchronous to `clk_i`. The count is held as two cascaded decade stages. Each stage raises a terminal-count-up enable when it must carry into the stage above, and a terminal-count-down enable when it must borrow from it.

A synchronous active-low load copies a 4-bit preset into each digit, so that a known occupancy can be restored. A synchronous active-low reset clears both digits. When the count wraps around 99→00 or 00→99, the block produces one-cycle carry and borrow flags from the tens stage. Display decoding and sensor conditioning sit outside the block.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `rst_n_i` is low at a rising clock edge, both digits become 0000 and `carry_o` and `borrow_o` become 0. This overrides load and both strobes.
- R2: With `load_n_i` high and neither strobe asserted, the count and both flags keep their values. Both flags are 0 in that case.
- R3: A lone `up_i` strobe adds one to the decimal count on the next edge. The ones digit going 9→0 increments the tens digit.
- R4: A lone `dn_i` strobe subtracts one from the decimal count on the next edge. The ones digit going 0→9 decrements the tens digit.
- R5: When `up_i` and `dn_i` are high in the same cycle, the cycle is treated as invalid. The count holds and neither flag is raised.
- R6: When `load_n_i` is low at an edge, the ones digit takes `preset_i[3:0]` and the tens digit takes `preset_i[7:4]`, and any strobe is ignored. Each digit is ordered with its least significant bit lowest, so `count_o[3:0]` is the ones digit and `count_o[7:4]` is the tens digit.
- R7: An up strobe at 99 gives 00. `carry_o` is 1 in exactly the one cycle following that edge.
- R8: A down strobe at 00 gives 99. `borrow_o` is 1 in exactly the one cycle following that edge.
- R9: A digit holding a loaded value above 9 behaves as follows. An up count that reaches it sets the digit to 0 and carries into the next digit. A down count that reaches it sets the digit to 9 without borrowing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low master reset |
| up_i | input | 1 | One-cycle count-up strobe |
| dn_i | input | 1 | One-cycle count-down strobe |
| load_n_i | input | 1 | Synchronous active-low parallel load |
| preset_i | input | 8 | Preset digits, ones in [3:0], tens in [7:4] |
| count_o | output | 8 | Current count, ones in [3:0], tens in [7:4] |
| carry_o | output | 1 | One-cycle pulse after a 99→00 wrap |
| borrow_o | output | 1 | One-cycle pulse after a 00→99 wrap |

## Verification
Every result is registered once. A strobe, load or reset applied before rising edge N shows on `count_o`, `carry_o` and `borrow_o` during the cycle after edge N. Each flag drops again at edge N+1 unless another wrap happens. The bench drives its inputs on the falling edge and withdraws them on the next falling edge, sampling the outputs at that same point, which is half a cycle after the edge that registered them. For the flag pulses, the bench checks the flag high in that sample and low again after one idle cycle.

// File: rtl/bcd_cnt_pkg.sv
// Shared constants and types for the BCD up/down counter.
// Assumes four-bit decimal digits; the digit count is a top-level parameter.
package bcd_cnt_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    // Per-cycle action chosen from the control inputs
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_INC  = 2'd1,
        CMD_DEC  = 2'd2,
        CMD_LOAD = 2'd3
    } cmd_t;

endpackage

// File: rtl/bcd_cmd_decode.sv
// Turns the load and strobe inputs into one action per cycle.
// Assumes the strobes are synchronous. Load wins over the strobes, and both
// strobes together give a hold. Reset is applied inside the storage stages.
module bcd_cmd_decode
    import bcd_cnt_pkg::*;
(
    input  logic up_i,
    input  logic dn_i,
    input  logic load_n_i,
    output cmd_t cmd_o
);

    // Priority selection of the cycle's action
    always_comb begin
        if (!load_n_i) begin
            cmd_o = CMD_LOAD;
        end else if (up_i && !dn_i) begin
            cmd_o = CMD_INC;
        end else if (dn_i && !up_i) begin
            cmd_o = CMD_DEC;
        end else begin
            cmd_o = CMD_HOLD;
        end
    end

endmodule

// File: rtl/bcd_decade_stage.sv
// One decimal digit with its terminal-count enables for the next stage.
// Assumes inc_en_i and dec_en_i are never high together. A value above 9
// is treated as terminal on up (goes to 0 and carries) and goes to 9 on down.
module bcd_decade_stage
    import bcd_cnt_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_n_i,
    input  logic   load_i,
    input  digit_t preset_i,
    input  logic   inc_en_i,
    input  logic   dec_en_i,
    output digit_t digit_o,
    output logic   tc_up_o,
    output logic   tc_dn_o
);

    digit_t digit_q;
    digit_t digit_nxt;

    // Terminal-count enables passed to the next stage
    always_comb begin
        tc_up_o = inc_en_i && (digit_q >= digit_t'(DIGIT_MAX));
        tc_dn_o = dec_en_i && (digit_q == '0);
    end

    // Next digit value for a count in either direction
    always_comb begin
        digit_nxt = digit_q;
        if (inc_en_i) begin
            if (digit_q >= digit_t'(DIGIT_MAX)) begin
                digit_nxt = '0;
            end else begin
                digit_nxt = digit_q + digit_t'(1);
            end
        end else if (dec_en_i) begin
            if (digit_q == '0 || digit_q > digit_t'(DIGIT_MAX)) begin
                digit_nxt = digit_t'(DIGIT_MAX);
            end else begin
                digit_nxt = digit_q - digit_t'(1);
            end
        end
    end

    // Digit storage with reset over load over count
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            digit_q <= '0;
        end else if (load_i) begin
            digit_q <= preset_i;
        end else begin
            digit_q <= digit_nxt;
        end
    end

    assign digit_o = digit_q;

endmodule

// File: rtl/bcd_wrap_flags.sv
// Registers the top stage's terminal-count enables as one-cycle wrap flags.
// Assumes the enables are already gated off during load.
module bcd_wrap_flags (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic top_tc_up_i,
    input  logic top_tc_dn_i,
    output logic carry_o,
    output logic borrow_o
);

    // Flag registers, cleared by reset
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            carry_o  <= 1'b0;
            borrow_o <= 1'b0;
        end else begin
            carry_o  <= top_tc_up_i;
            borrow_o <= top_tc_dn_i;
        end
    end

endmodule

// File: rtl/bcd_updown_counter.sv
// Cascaded decimal up/down counter with parallel load and wrap flags.
// Assumes synchronous one-cycle strobes. Digit k occupies count_o[4k+3:4k].
module bcd_updown_counter
    import bcd_cnt_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int CW = DIGITS * DIGIT_W
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          up_i,
    input  logic          dn_i,
    input  logic          load_n_i,
    input  logic [CW-1:0] preset_i,
    output logic [CW-1:0] count_o,
    output logic          carry_o,
    output logic          borrow_o
);

    cmd_t              cmd;
    logic              load;
    logic [DIGITS:0]   inc_chain;
    logic [DIGITS:0]   dec_chain;

    bcd_cmd_decode u_decode (
        .up_i     (up_i),
        .dn_i     (dn_i),
        .load_n_i (load_n_i),
        .cmd_o    (cmd)
    );

    // Entry points of the carry and borrow chains
    always_comb begin
        load         = (cmd == CMD_LOAD);
        inc_chain[0] = (cmd == CMD_INC);
        dec_chain[0] = (cmd == CMD_DEC);
    end

    for (genvar k = 0; k < DIGITS; k++) begin : g_stage
        bcd_decade_stage u_stage (
            .clk_i    (clk_i),
            .rst_n_i  (rst_n_i),
            .load_i   (load),
            .preset_i (preset_i[k*DIGIT_W +: DIGIT_W]),
            .inc_en_i (inc_chain[k]),
            .dec_en_i (dec_chain[k]),
            .digit_o  (count_o[k*DIGIT_W +: DIGIT_W]),
            .tc_up_o  (inc_chain[k+1]),
            .tc_dn_o  (dec_chain[k+1])
        );
    end

    bcd_wrap_flags u_flags (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .top_tc_up_i (inc_chain[DIGITS]),
        .top_tc_dn_i (dec_chain[DIGITS]),
        .carry_o     (carry_o),
        .borrow_o    (borrow_o)
    );

endmodule

// File: rtl/bcd_updown_counter_chk.sv
// Port-level properties of the two-digit counter, bound to every instance.
module bcd_updown_counter_chk (
    input logic       clk_i,
    input logic       rst_n_i,
    input logic       up_i,
    input logic       dn_i,
    input logic       load_n_i,
    input logic [7:0] preset_i,
    input logic [7:0] count_o,
    input logic       carry_o,
    input logic       borrow_o
);

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        !rst_n_i |=> (count_o == 8'h00 && !carry_o && !borrow_o));

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && !up_i && !dn_i) |=> ($stable(count_o) && !carry_o && !borrow_o));

    assert_both_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && up_i && dn_i) |=> ($stable(count_o) && !carry_o && !borrow_o));

    assert_load_preset_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !load_n_i |=> (count_o == $past(preset_i) && !carry_o && !borrow_o));

    assert_up_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && up_i && !dn_i && count_o == 8'h99) |=> (count_o == 8'h00 && carry_o));

    assert_carry_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        carry_o |-> count_o == 8'h00);

    assert_carry_single_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        carry_o |=> !carry_o);

    assert_down_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && dn_i && !up_i && count_o == 8'h00) |=> (count_o == 8'h99 && borrow_o));

    assert_borrow_at_max_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        borrow_o |-> count_o == 8'h99);

    assert_flags_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $countones({carry_o, borrow_o}) <= 1);

    assert_ones_invalid_up_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && up_i && !dn_i && count_o[3:0] > 4'd9) |=> count_o[3:0] == 4'd0);

    assert_ones_invalid_dn_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_n_i && dn_i && !up_i && count_o[3:0] > 4'd9) |=> count_o[3:0] == 4'd9);

endmodule

bind bcd_updown_counter bcd_updown_counter_chk u_chk (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .up_i     (up_i),
    .dn_i     (dn_i),
    .load_n_i (load_n_i),
    .preset_i (preset_i),
    .count_o  (count_o),
    .carry_o  (carry_o),
    .borrow_o (borrow_o)
);

// File: tb/bcd_updown_counter_tb_top.sv
// Directed bench: inputs change on the falling edge, outputs are sampled
// at the next falling edge, half a cycle after the registering edge.
module bcd_updown_counter_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_n_i = 1'b0;
    logic       up_i = 1'b0;
    logic       dn_i = 1'b0;
    logic       load_n_i = 1'b1;
    logic [7:0] preset_i = 8'h00;
    logic [7:0] count_o;
    logic       carry_o;
    logic       borrow_o;

    int checks = 0;
    int errors = 0;

    always #2 clk_i = ~clk_i;

    bcd_updown_counter dut_i (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .up_i     (up_i),
        .dn_i     (dn_i),
        .load_n_i (load_n_i),
        .preset_i (preset_i),
        .count_o  (count_o),
        .carry_o  (carry_o),
        .borrow_o (borrow_o)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    // Compare {carry, borrow, count} with the expected value
    task automatic check(input string req, input logic [7:0] exp_cnt,
                         input logic exp_c, input logic exp_b);
        checks++;
        if (count_o !== exp_cnt || carry_o !== exp_c || borrow_o !== exp_b) begin
            errors++;
            $display("FAIL %s: actual count=%h carry=%b borrow=%b expected count=%h carry=%b borrow=%b",
                     req, count_o, carry_o, borrow_o, exp_cnt, exp_c, exp_b);
        end
    endtask

    // Apply one cycle of inputs, starting and ending on a falling edge
    task automatic apply(input logic rst_n, input logic up, input logic dn,
                         input logic ld_n, input logic [7:0] pre);
        rst_n_i  = rst_n;
        up_i     = up;
        dn_i     = dn;
        load_n_i = ld_n;
        preset_i = pre;
        @(negedge clk_i);
        rst_n_i  = 1'b1;
        up_i     = 1'b0;
        dn_i     = 1'b0;
        load_n_i = 1'b1;
    endtask

    task automatic load(input logic [7:0] v);
        apply(1'b1, 1'b0, 1'b0, 1'b0, v);
    endtask

    task automatic t_reset();
        apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h55);
        check("R1 reset over load and up", 8'h00, 1'b0, 1'b0);
        load(8'h37);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R1 reset mid-run", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_idle_load();
        load(8'h42);
        check("R6 load 42", 8'h42, 1'b0, 1'b0);
        repeat (3) @(negedge clk_i);
        check("R2 idle hold", 8'h42, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h23);
        check("R6 load over up strobe", 8'h23, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b1, 1'b0, 8'h61);
        check("R6 load over down strobe, ones in [3:0]", 8'h61, 1'b0, 1'b0);
    endtask

    task automatic t_up_down();
        load(8'h07);
        for (int i = 8; i <= 12; i++) begin
            apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
            check("R3 up step", to_bcd(i), 1'b0, 1'b0);
        end
        for (int i = 11; i >= 8; i--) begin
            apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
            check("R4 down step", to_bcd(i), 1'b0, 1'b0);
        end
    endtask

    task automatic t_both();
        load(8'h08);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        check("R5 both strobes hold at 08", 8'h08, 1'b0, 1'b0);
        load(8'h99);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        check("R5 both strobes hold at 99, no carry", 8'h99, 1'b0, 1'b0);
        load(8'h00);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        check("R5 both strobes hold at 00, no borrow", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_wraps();
        load(8'h98);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        check("R3 up to 99 no carry", 8'h99, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        check("R7 wrap 99 to 00 with carry", 8'h00, 1'b1, 1'b0);
        @(negedge clk_i);
        check("R7 carry lasts one cycle", 8'h00, 1'b0, 1'b0);
        load(8'h01);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R4 down to 00 no borrow", 8'h00, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R8 wrap 00 to 99 with borrow", 8'h99, 1'b0, 1'b1);
        @(negedge clk_i);
        check("R8 borrow lasts one cycle", 8'h99, 1'b0, 1'b0);
    endtask

    task automatic t_bad_preset();
        load(8'h0C);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        check("R9 ones 12 up carries", 8'h10, 1'b0, 1'b0);
        load(8'h0D);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R9 ones 13 down to 9 no borrow", 8'h09, 1'b0, 1'b0);
        load(8'hB5);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        check("R9 tens 11 untouched without carry", 8'hB6, 1'b0, 1'b0);
        load(8'hF9);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        check("R9 tens 15 carry-in wraps to 0 with carry", 8'h00, 1'b1, 1'b0);
        load(8'hC0);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R9 tens 12 borrow-in gives 9 no borrow", 8'h99, 1'b0, 1'b0);
    endtask

    task automatic t_sweep();
        int model = 0;
        load(8'h00);
        for (int i = 0; i < 100; i++) begin
            apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
            model = (model + 1) % 100;
            check("R3 sweep up", to_bcd(model), model == 0, 1'b0);
        end
        for (int i = 0; i < 100; i++) begin
            apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
            model = (model + 99) % 100;
            check("R4 sweep down", to_bcd(model), 1'b0, model == 99);
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (50000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk_i);
        @(negedge clk_i);
        t_reset();
        t_idle_load();
        t_up_down();
        t_both();
        t_wraps();
        t_bad_preset();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule